// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block holds a time-of-day value as a 32-bit seconds word and a 32-bit nanoseconds word. On every increment tick it adds a programmable 8-bit subsecond step to the nanoseconds word. The nanoseconds word wraps at one billion and carries into the seconds word. In coarse mode every clock is a tick. In fine mode a 32-bit rate word is added to a free-running 32-bit accumulator on every clock, and a tick happens only on the clocks where that sum carries out. The rate word therefore sets the average tick rate.

Software changes the time through three command requests: load a new time, apply a signed offset, and load a new rate word. Each request raises a busy bit that clears by itself on the clock that applies the command. The block drives the current time and a one-cycle pulse on each change of the seconds value. All pins are plain control and status pins; there is no streaming interface and so no back-pressure.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset, time_sec and time_ns are 0, all busy outputs and sec_pulse are 0, and the rate word is 0. With a rate word of 0, fine mode produces no ticks.
- R2: In coarse mode (fine_en=0), time_ns grows by step_ns on every clock that applies no time command.
- R3: If a step would bring time_ns to 1,000,000,000 or more, time_ns becomes that sum minus 1,000,000,000 and time_sec grows by 1. time_ns never reads 1,000,000,000 or more.
- R4: The 32-bit accumulator adds the rate word on every clock. In fine mode (fine_en=1), a tick happens only when that 33-bit sum has bit 32 set. With a rate word of 0x8000_0000 the time therefore advances on every second clock.
- R5: A clock with init_req=1 and no time command busy captures set_sec and set_ns and raises init_busy. On the next clock time_sec and time_ns take the captured values, init_busy returns to 0, and that clock adds no step.
- R6: A clock with upd_req=1, no time command busy and init_req=0 captures set_sec and set_ns and raises upd_busy. If bit 31 of the captured set_ns is 0, the next clock adds set_sec seconds and bits 30:0 nanoseconds to the time, carrying into the seconds. upd_busy clears on that clock, and that clock adds no step.
- R7: If bit 31 of the captured set_ns is 1, the update subtracts. Bits 30:0 hold 1,000,000,000 minus the nanosecond magnitude, and set_sec holds the seconds magnitude. The result equals the time minus the magnitude, borrowing from the seconds when needed.
- R8: A clock with rate_req=1 and addend_busy=0 captures rate_in and raises addend_busy. The next clock copies the captured value into the rate word and clears addend_busy. That clock still accumulates with the old rate word.
- R9: A request on a clock where its busy bit is set is ignored. init_busy and upd_busy together form one time-command slot. When init_req and upd_req arrive together, init wins and the update is dropped.
- R10: sec_pulse is 1 for exactly the clocks in which time_sec holds a value different from the one it held in the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fine_en | input | 1 | 1 = tick on accumulator carry, 0 = tick every clock |
| step_ns | input | 8 | Nanoseconds added per tick |
| set_sec | input | 32 | Staged seconds for init or update |
| set_ns | input | 32 | Staged nanoseconds; bit 31 selects subtraction on update |
| rate_in | input | 32 | Staged rate word |
| init_req | input | 1 | Request: load the staged time |
| upd_req | input | 1 | Request: apply the staged offset |
| rate_req | input | 1 | Request: load the staged rate word |
| init_busy | output | 1 | Time load pending |
| upd_busy | output | 1 | Offset update pending |
| addend_busy | output | 1 | Rate word load pending |
| time_sec | output | 32 | Current seconds |
| time_ns | output | 32 | Current nanoseconds |
| sec_pulse | output | 1 | One-cycle pulse on a change of the seconds value |

## Verification
The bench goes after these boundaries:
- A step that lands exactly on one billion. A design with an off-by-one compare would show 1,000,000,000 or fail to carry.
- Subtractions of zero and of a magnitude larger than the current nanoseconds. A wrong borrow would leave the seconds one too high or low.
- Requests issued while a command is busy, and init and update requested together. A design that queues or overwrites would change the time or the capture.
- A rate word of one half, checked against the exact tick count, and a rate load whose effect must wait one clock. A design that gets the carry or the handover wrong would advance at the wrong moment.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
  localparam int unsigned SEC_W = 32;
  localparam int unsigned NS_W  = 32;
  localparam int unsigned STEP_W = 8;
  localparam int unsigned RATE_W = 32;
  localparam logic [NS_W-1:0] NS_PER_SEC = 32'd1_000_000_000;
endpackage

// File: rtl/ptp_cmd_ctrl.sv
module ptp_cmd_ctrl #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned NS_W   = 32,
  parameter int unsigned RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic              upd_req,
  input  logic              rate_req,
  input  logic [SEC_W-1:0]  set_sec,
  input  logic [NS_W-1:0]   set_ns,
  input  logic [RATE_W-1:0] rate_in,
  output logic              pend_init,
  output logic              pend_upd,
  output logic              pend_rate,
  output logic [SEC_W-1:0]  cap_sec,
  output logic [NS_W-1:0]   cap_ns,
  output logic [RATE_W-1:0] cap_rate
);
  logic slot_busy;
  assign slot_busy = pend_init | pend_upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_init <= 1'b0;
      pend_upd  <= 1'b0;
      cap_sec   <= '0;
      cap_ns    <= '0;
    end else if (slot_busy) begin
      pend_init <= 1'b0;
      pend_upd  <= 1'b0;
    end else if (init_req || upd_req) begin
      pend_init <= init_req;
      pend_upd  <= ~init_req;
      cap_sec   <= set_sec;
      cap_ns    <= set_ns;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_rate <= 1'b0;
      cap_rate  <= '0;
    end else if (pend_rate) begin
      pend_rate <= 1'b0;
    end else if (rate_req) begin
      pend_rate <= 1'b1;
      cap_rate  <= rate_in;
    end
  end

  AST_ONE_TIME_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_init && pend_upd)); // R9
  AST_INIT_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    pend_init |=> !pend_init); // R5
  AST_UPD_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    pend_upd |=> !pend_upd); // R6
  AST_RATE_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rate |=> !pend_rate); // R8
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    slot_busy |=> $stable(cap_ns) && $stable(cap_sec)); // R9
endmodule

// File: rtl/ptp_rate_gen.sv
module ptp_rate_gen #(
  parameter int unsigned RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fine_en,
  input  logic              load,
  input  logic [RATE_W-1:0] load_val,
  output logic              tick
);
  logic [RATE_W-1:0] rate_q;
  logic [RATE_W-1:0] acc_q;
  logic [RATE_W:0]   acc_sum;

  assign acc_sum = {1'b0, acc_q} + {1'b0, rate_q};
  assign tick    = fine_en ? acc_sum[RATE_W] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rate_q <= '0;
    end else begin
      acc_q <= acc_sum[RATE_W-1:0];
      if (load) rate_q <= load_val;
    end
  end

  AST_ZERO_RATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fine_en && rate_q == '0) |-> !tick); // R4
endmodule

// File: rtl/ptp_time_core.sv
module ptp_time_core
  import ptp_pkg::*;
#(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned NS_W   = 32,
  parameter int unsigned STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [STEP_W-1:0] step_ns,
  input  logic              do_init,
  input  logic              do_upd,
  input  logic [SEC_W-1:0]  cap_sec,
  input  logic [NS_W-1:0]   cap_ns,
  output logic [SEC_W-1:0]  time_sec,
  output logic [NS_W-1:0]   time_ns,
  output logic              sec_pulse
);
  localparam int unsigned SUM_W = NS_W + 1;
  localparam logic [SUM_W-1:0] LIMIT = {1'b0, NS_PER_SEC};

  logic [SUM_W-1:0] step_sum, off_sum;
  logic             sub_mode;
  logic [SEC_W-1:0] sec_nx;
  logic [NS_W-1:0]  ns_nx;

  assign step_sum = {1'b0, time_ns} + SUM_W'(step_ns);
  assign off_sum  = {1'b0, time_ns} + {2'b00, cap_ns[NS_W-2:0]};
  assign sub_mode = cap_ns[NS_W-1];

  always_comb begin
    sec_nx = time_sec;
    ns_nx  = time_ns;
    if (do_init) begin
      sec_nx = cap_sec;
      ns_nx  = cap_ns;
    end else if (do_upd) begin
      if (off_sum >= LIMIT) begin
        ns_nx  = NS_W'(off_sum - LIMIT);
        sec_nx = sub_mode ? time_sec - cap_sec : time_sec + cap_sec + 1'b1;
      end else begin
        ns_nx  = off_sum[NS_W-1:0];
        sec_nx = sub_mode ? time_sec - cap_sec - 1'b1 : time_sec + cap_sec;
      end
    end else if (tick) begin
      if (step_sum >= LIMIT) begin
        ns_nx  = NS_W'(step_sum - LIMIT);
        sec_nx = time_sec + 1'b1;
      end else begin
        ns_nx  = step_sum[NS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_sec  <= '0;
      time_ns   <= '0;
      sec_pulse <= 1'b0;
    end else begin
      time_sec  <= sec_nx;
      time_ns   <= ns_nx;
      sec_pulse <= (sec_nx != time_sec);
    end
  end

  AST_NS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    time_ns < NS_PER_SEC); // R3
  AST_SEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> time_sec != $past(time_sec)); // R10
  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    do_init |=> time_sec == $past(cap_sec) && time_ns == $past(cap_ns)); // R5
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fine_en,
  input  logic [STEP_W-1:0] step_ns,
  input  logic [SEC_W-1:0]  set_sec,
  input  logic [NS_W-1:0]   set_ns,
  input  logic [RATE_W-1:0] rate_in,
  input  logic              init_req,
  input  logic              upd_req,
  input  logic              rate_req,
  output logic              init_busy,
  output logic              upd_busy,
  output logic              addend_busy,
  output logic [SEC_W-1:0]  time_sec,
  output logic [NS_W-1:0]   time_ns,
  output logic              sec_pulse
);
  logic [SEC_W-1:0]  cap_sec;
  logic [NS_W-1:0]   cap_ns;
  logic [RATE_W-1:0] cap_rate;
  logic              tick;

  ptp_cmd_ctrl #(.SEC_W(SEC_W), .NS_W(NS_W), .RATE_W(RATE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .upd_req(upd_req),
    .rate_req(rate_req), .set_sec(set_sec), .set_ns(set_ns), .rate_in(rate_in),
    .pend_init(init_busy), .pend_upd(upd_busy), .pend_rate(addend_busy),
    .cap_sec(cap_sec), .cap_ns(cap_ns), .cap_rate(cap_rate));

  ptp_rate_gen #(.RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .fine_en(fine_en), .load(addend_busy),
    .load_val(cap_rate), .tick(tick));

  ptp_time_core #(.SEC_W(SEC_W), .NS_W(NS_W), .STEP_W(STEP_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step_ns(step_ns),
    .do_init(init_busy), .do_upd(upd_busy), .cap_sec(cap_sec), .cap_ns(cap_ns),
    .time_sec(time_sec), .time_ns(time_ns), .sec_pulse(sec_pulse));

  AST_COARSE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fine_en && !init_busy && !upd_busy && time_ns < 32'd999_000_000)
      |=> time_ns == $past(time_ns) + 32'($past(step_ns))); // R2
endmodule

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam longint NSPS = 64'd1_000_000_000;

  logic clk = 0, rst_n = 0;
  logic fine_en = 0;
  logic [7:0] step_ns = 0;
  logic [31:0] set_sec = 0, set_ns = 0, rate_in = 0;
  logic init_req = 0, upd_req = 0, rate_req = 0;
  logic init_busy, upd_busy, addend_busy, sec_pulse;
  logic [31:0] time_sec, time_ns;

  int vectors = 0, fails = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_time_counter u_dut (
    .clk(clk), .rst_n(rst_n), .fine_en(fine_en), .step_ns(step_ns),
    .set_sec(set_sec), .set_ns(set_ns), .rate_in(rate_in),
    .init_req(init_req), .upd_req(upd_req), .rate_req(rate_req),
    .init_busy(init_busy), .upd_busy(upd_busy), .addend_busy(addend_busy),
    .time_sec(time_sec), .time_ns(time_ns), .sec_pulse(sec_pulse));

  // reference model built from the requirements, total nanoseconds based
  longint m_total;
  logic [31:0] m_acc, m_rate, c_sec, c_ns, c_rate;
  logic m_pi, m_pu, m_pa, m_pulse;

  function automatic longint apply_offset(longint t, logic [31:0] s, logic [31:0] n);
    longint mag;
    if (!n[31]) return t + longint'(s) * NSPS + longint'(n[30:0]);
    mag = longint'(s) * NSPS + (NSPS - longint'(n[30:0]));
    return t - mag;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_total <= 0; m_acc <= 0; m_rate <= 0; m_pi <= 0; m_pu <= 0; m_pa <= 0;
      m_pulse <= 0; c_sec <= 0; c_ns <= 0; c_rate <= 0;
    end else begin
      logic [32:0] s;
      logic tk;
      longint nt;
      s = {1'b0, m_acc} + {1'b0, m_rate};
      tk = fine_en ? s[32] : 1'b1;
      m_acc <= s[31:0];
      nt = m_total;
      if (m_pi) nt = longint'(c_sec) * NSPS + longint'(c_ns);
      else if (m_pu) nt = apply_offset(m_total, c_sec, c_ns);
      else if (tk) nt = m_total + longint'(step_ns);
      m_total <= nt;
      m_pulse <= (nt / NSPS) != (m_total / NSPS);
      if (m_pa) m_rate <= c_rate;
      if (m_pi || m_pu) begin m_pi <= 0; m_pu <= 0; end
      else if (init_req) begin m_pi <= 1; c_sec <= set_sec; c_ns <= set_ns; end
      else if (upd_req) begin m_pu <= 1; c_sec <= set_sec; c_ns <= set_ns; end
      if (m_pa) m_pa <= 0;
      else if (rate_req) begin m_pa <= 1; c_rate <= rate_in; end
    end
  end

  task automatic check(string t, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check(tag, "sec", time_sec, m_total / NSPS);
    check(tag, "ns", time_ns, m_total % NSPS);
    check(tag, "pulse", sec_pulse, m_pulse);
    check(tag, "busy", {init_busy, upd_busy, addend_busy}, {m_pi, m_pu, m_pa});
  endtask

  task automatic do_init(longint s, longint n);
    set_sec = 32'(s); set_ns = 32'(n); init_req = 1; step(); init_req = 0; step();
  endtask

  task automatic do_upd(logic [31:0] s, logic [31:0] n);
    set_sec = s; set_ns = n; upd_req = 1; step(); upd_req = 0; step();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] s0, n0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1", "sec at reset", time_sec, 0);
    check("R1", "ns at reset", time_ns, 0);
    check("R1", "busy at reset", {init_busy, upd_busy, addend_busy, sec_pulse}, 0);
    rst_n = 1;
    // R1: zero rate word in fine mode gives no ticks
    tag = "R1"; fine_en = 1; step_ns = 8'd50;
    repeat (5) step();
    check("R1", "no fine ticks with zero rate", time_ns, 0);
    // R2 coarse stepping
    tag = "R2"; fine_en = 0; step_ns = 8'd7;
    repeat (4) step();
    check("R2", "coarse 4 steps of 7", time_ns, 28);
    // R5 init and R3 exact rollover
    tag = "R5"; do_init(5, 999_999_980);
    check("R5", "init sec", time_sec, 5);
    tag = "R3"; step_ns = 8'd20; step();
    check("R3", "exact rollover ns", time_ns, 0);
    check("R10", "pulse on rollover", sec_pulse, 1);
    tag = "R10"; step();
    check("R10", "pulse one cycle", sec_pulse, 0);
    // R4 half rate: advances every second clock
    tag = "R8"; step_ns = 8'd10; fine_en = 1;
    rate_in = 32'h8000_0000; rate_req = 1; step(); rate_req = 0; step();
    tag = "R4"; n0 = time_ns; repeat (8) step();
    check("R4", "half rate 8 clocks", time_ns - n0, 40);
    // R6 add with carry
    tag = "R6"; fine_en = 0; step_ns = 0;
    do_init(10, 900_000_000);
    do_upd(32'd3, 32'd200_000_000);
    check("R6", "add carry sec", time_sec, 14);
    check("R6", "add carry ns", time_ns, 100_000_000);
    // R7 subtract with borrow: minus 2 s 300 ms
    tag = "R7"; do_upd(32'd2, {1'b1, 31'(1_000_000_000 - 300_000_000)});
    check("R7", "sub borrow sec", time_sec, 11);
    check("R7", "sub borrow ns", time_ns, 800_000_000);
    do_upd(32'd0, {1'b1, 31'd1_000_000_000});
    check("R7", "sub zero unchanged", time_ns, 800_000_000);
    // R9 requests while busy ignored; init wins over update
    tag = "R9"; set_sec = 77; set_ns = 5; init_req = 1; step();
    set_sec = 99; set_ns = 6; init_req = 1; upd_req = 1; step();
    init_req = 0; upd_req = 0; step();
    check("R9", "busy request dropped sec", time_sec, 77);
    set_sec = 40; set_ns = 1; init_req = 1; upd_req = 1; step();
    init_req = 0; upd_req = 0; step();
    check("R9", "init wins sec", time_sec, 40);
    check("R9", "init wins ns", time_ns, 1);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      tag = "R2";
      fine_en = ($urandom_range(0, 3) == 0);
      step_ns = 8'($urandom);
      init_req = 0; upd_req = 0; rate_req = 0;
      if (r < 3) begin
        tag = "R5"; init_req = 1; set_sec = $urandom_range(20, 1000);
        set_ns = $urandom_range(0, 999_999_999);
      end else if (r < 6) begin
        tag = "R6"; upd_req = 1; set_sec = $urandom_range(0, 5);
        set_ns = $urandom_range(0, 999_999_999);
      end else if (r < 9 && m_total > 20 * NSPS) begin
        tag = "R7"; upd_req = 1; set_sec = $urandom_range(0, 5);
        s0 = $urandom_range(0, 999_999_999);
        set_ns = {1'b1, 31'(NSPS - longint'(s0))};
      end
      if (r >= 95) begin tag = "R8"; rate_req = 1; rate_in = $urandom; end
      step();
    end
    init_req = 0; upd_req = 0; rate_req = 0;
    step();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule